// File: doc/BRIEF.md
# Quarter-Carry Arithmetic and Logic Unit

This block is the arithmetic and logic unit of a 16-bit datapath. It takes an operation code, two operands and the current flag word. It produces a result and a new flag word. Besides the usual carry, zero, negative and overflow flags, it reports the carry (or borrow) out of each quarter of the word, so software can do nibble-wise decimal correction and similar work without extra instructions.

Every operation writes only the flags it is defined to affect. All other flag bits are copied unchanged from the incoming flag word. Shifts pass bits through the carry flag. Rotates and the byte swap leave every flag as it was. The result and the flags are registered. A new pair is captured on each clock edge where the execute strobe is high, so the block fits a single execute stage.

Top module: `alu16q`

## Requirements
- R1: While reset (rst_n low) is asserted, result_o and flags_o read zero.
- R2: Outputs change only on a rising clock edge with exec_i high, and then appear one clock later. With exec_i low, both outputs hold. Operation codes on op_i: 0 add, 1 increment, 2 subtract, 3 decrement, 4 AND, 5 OR, 6 XOR, 7 NOT, 8 shift left, 9 shift right, 10 rotate left, 11 rotate right, 12 byte swap.
- R3: The flag word has these bit positions: 0 carry C, 1 quarter carry QC, 2 half carry HC, 3 three-quarter carry TC, 4 zero Z, 5 negative N, 6 overflow O. Add produces A+B and increment produces A+1, modulo 2^16. C is the carry out of bit 15. QC, HC and TC are the carries out of bits 3, 7 and 11.
- R4: Subtract produces A−B and decrement produces A−1. C, QC, HC and TC are set when a borrow leaves bit 15, 3, 7 or 11 respectively. This means C is set exactly when A is less than B unsigned.
- R5: For the four arithmetic operations, Z is set when the result is zero, N equals bit 15 of the result, and O flags two's-complement overflow. All seven flags are written.
- R6: AND, OR, XOR (A with B) and NOT (of A) write only Z. Bits 0–3, 5 and 6 copy flags_i.
- R7: Shift left gives {A[14:0], old C}. The new C is A[15]. Z is set when the result is zero. No other flag changes.
- R8: Shift right gives {old C, A[15:1]}. The new C is A[0]. Z is set when the result is zero. No other flag changes.
- R9: Rotate left gives {A[14:0], A[15]}. Rotate right gives {A[0], A[15:1]}. flags_o equals flags_i.
- R10: Byte swap gives {A[7:0], A[15:8]}. flags_o equals flags_i.
- R11: Codes 13–15 pass A through to the result and copy flags_i to flags_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_i | input | 1 | Capture the result of this cycle's operation |
| op_i | input | 4 | Operation code |
| a_i | input | 16 | Operand A (destination register value) |
| b_i | input | 16 | Operand B (source register or constant) |
| flags_i | input | 7 | Current flag word |
| result_o | output | 16 | Registered result |
| flags_o | output | 7 | Registered new flag word |

## Verification
The arithmetic operations are driven with operands built so that a carry or borrow stops exactly at one quarter boundary. Examples are 0x000F+1, 0x00FF+1, 0x0FFF+1, 0xFFFF+1 and 0x0000−1. These show whether each quarter carry is tapped at the right bit and inverted for borrows. The sign-boundary cases 0x7FFF+1 and 0x8000−1 separate overflow from carry. Shifts are run with both values of the incoming carry, and every operation is run with a flag word whose unaffected bits are all set and then all clear, so a flag written by mistake shows up. A long run of random operands, codes and flag words, with the strobe sometimes low, covers the rest of the encoding and the hold behaviour.

// File: rtl/alu16q_pkg.sv
package alu16q_pkg;
   localparam int FLAG_W = 7;
   localparam int FB_C   = 0;
   localparam int FB_QC  = 1;
   localparam int FB_HC  = 2;
   localparam int FB_TC  = 3;
   localparam int FB_Z   = 4;
   localparam int FB_N   = 5;
   localparam int FB_O   = 6;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_INC  = 4'd1,
      OP_SUB  = 4'd2,
      OP_DEC  = 4'd3,
      OP_AND  = 4'd4,
      OP_OR   = 4'd5,
      OP_XOR  = 4'd6,
      OP_NOT  = 4'd7,
      OP_SHL  = 4'd8,
      OP_SHR  = 4'd9,
      OP_ROL  = 4'd10,
      OP_ROR  = 4'd11,
      OP_SWAP = 4'd12
   } op_e;

   localparam logic [FLAG_W-1:0] MASK_ARITH = 7'b111_1111;
   localparam logic [FLAG_W-1:0] MASK_LOGIC = 7'b001_0000;
   localparam logic [FLAG_W-1:0] MASK_SHIFT = 7'b001_0001;
   localparam logic [FLAG_W-1:0] MASK_NONE  = 7'b000_0000;
endpackage

// File: rtl/alu16q_arith.sv
module alu16q_arith #(
   parameter int W = 16
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         sub_i,
   output logic [W-1:0] sum_o,
   output logic         carry_o,
   output logic [2:0]   qcar_o,
   output logic         ovf_o
);
   localparam int Q = W / 4;

   logic [W-1:0] b_eff;
   logic [4:0]   cy;

   assign b_eff = sub_i ? ~b_i : b_i;
   assign cy[0] = sub_i;

   for (genvar k = 0; k < 4; k++) begin : g_quarter
      logic [Q:0] part;
      assign part = {1'b0, a_i[k*Q +: Q]} + {1'b0, b_eff[k*Q +: Q]}
                  + {{Q{1'b0}}, cy[k]};
      assign sum_o[k*Q +: Q] = part[Q-1:0];
      assign cy[k+1]         = part[Q];
   end

   // borrow is the inverse of the raw carry when subtracting
   assign carry_o = cy[4] ^ sub_i;
   assign qcar_o  = cy[3:1] ^ {3{sub_i}};
   assign ovf_o   = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);
endmodule

// File: rtl/alu16q_logic.sv
module alu16q_logic #(
   parameter int W = 16
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic [1:0]   sel_i,
   output logic [W-1:0] res_o
);
   always_comb begin
      unique case (sel_i)
         2'd0:    res_o = a_i & b_i;
         2'd1:    res_o = a_i | b_i;
         2'd2:    res_o = a_i ^ b_i;
         default: res_o = ~a_i;
      endcase
   end
endmodule

// File: rtl/alu16q_shift.sv
module alu16q_shift #(
   parameter int W = 16
) (
   input  logic [W-1:0] a_i,
   input  logic         cin_i,
   input  logic [2:0]   sel_i,
   output logic [W-1:0] res_o,
   output logic         cout_o
);
   localparam int H = W / 2;

   always_comb begin
      cout_o = cin_i;
      unique case (sel_i)
         3'd0: begin
            res_o  = {a_i[W-2:0], cin_i};
            cout_o = a_i[W-1];
         end
         3'd1: begin
            res_o  = {cin_i, a_i[W-1:1]};
            cout_o = a_i[0];
         end
         3'd2:    res_o = {a_i[W-2:0], a_i[W-1]};
         3'd3:    res_o = {a_i[0], a_i[W-1:1]};
         default: res_o = {a_i[H-1:0], a_i[W-1:H]};
      endcase
   end
endmodule

// File: rtl/alu16q.sv
module alu16q
   import alu16q_pkg::*;
#(
   parameter int W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exec_i,
   input  logic [3:0]        op_i,
   input  logic [W-1:0]      a_i,
   input  logic [W-1:0]      b_i,
   input  logic [FLAG_W-1:0] flags_i,
   output logic [W-1:0]      result_o,
   output logic [FLAG_W-1:0] flags_o
);
   if ((W % 8) != 0 || W < 8) begin : g_bad_width
      $error("alu16q: W must be a multiple of 8 and at least 8");
   end

   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] b_arith, sum, logic_res, shift_res;
   logic         is_sub, carry, ovf, shift_c;
   logic [2:0]   qcar;
   logic [W-1:0] res_d;
   logic [FLAG_W-1:0] calc, mask, flags_d;

   assign is_sub  = (op_i == OP_SUB) || (op_i == OP_DEC);
   assign b_arith = (op_i == OP_INC || op_i == OP_DEC) ? ONE : b_i;

   alu16q_arith #(.W(W)) arith_i (
      .a_i(a_i), .b_i(b_arith), .sub_i(is_sub),
      .sum_o(sum), .carry_o(carry), .qcar_o(qcar), .ovf_o(ovf)
   );

   alu16q_logic #(.W(W)) logic_i (
      .a_i(a_i), .b_i(b_i), .sel_i(op_i[1:0]), .res_o(logic_res)
   );

   alu16q_shift #(.W(W)) shift_i (
      .a_i(a_i), .cin_i(flags_i[FB_C]), .sel_i(op_i[2:0]),
      .res_o(shift_res), .cout_o(shift_c)
   );

   always_comb begin
      calc = '0;
      if (op_i[3:2] == 2'b00) begin
         res_d = sum;
         mask  = MASK_ARITH;
      end else if (op_i[3:2] == 2'b01) begin
         res_d = logic_res;
         mask  = MASK_LOGIC;
      end else if (op_i <= 4'(OP_SWAP)) begin
         res_d = shift_res;
         mask  = (op_i[3:1] == 3'b100) ? MASK_SHIFT : MASK_NONE;
      end else begin
         res_d = a_i;
         mask  = MASK_NONE;
      end
      calc[FB_C]  = (op_i[3:2] == 2'b00) ? carry : shift_c;
      calc[FB_QC] = qcar[0];
      calc[FB_HC] = qcar[1];
      calc[FB_TC] = qcar[2];
      calc[FB_Z]  = (res_d == '0);
      calc[FB_N]  = res_d[W-1];
      calc[FB_O]  = ovf;
      flags_d     = (flags_i & ~mask) | (calc & mask);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result_o <= '0;
         flags_o  <= '0;
      end else if (exec_i) begin
         result_o <= res_d;
         flags_o  <= flags_d;
      end
   end
endmodule

// File: rtl/alu16q_chk.sv
module alu16q_chk
   import alu16q_pkg::*;
#(
   parameter int W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              exec_i,
   input logic [3:0]        op_i,
   input logic [W-1:0]      a_i,
   input logic [FLAG_W-1:0] flags_i,
   input logic [W-1:0]      result_o,
   input logic [FLAG_W-1:0] flags_o
);
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_i |=> ($stable(result_o) && $stable(flags_o)));                 // R2

   AST_NEG_IS_MSB: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_i && op_i[3:2] == 2'b00) |=> (flags_o[FB_N] == result_o[W-1]));  // R5

   AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_i && op_i <= 4'd9) |=> (flags_o[FB_Z] == (result_o == '0)));     // R5

   AST_LOGIC_ONLY_Z: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_i && op_i[3:2] == 2'b01) |=>
      ({flags_o[6:5], flags_o[3:0]} == {$past(flags_i[6:5]), $past(flags_i[3:0])})); // R6

   AST_SHL_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_i && op_i == 4'd8) |=>
      (flags_o[FB_C] == $past(a_i[W-1]) && result_o[0] == $past(flags_i[FB_C]))); // R7

   AST_SHR_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_i && op_i == 4'd9) |=>
      (flags_o[FB_C] == $past(a_i[0]) && result_o[W-1] == $past(flags_i[FB_C]))); // R8

   AST_ROT_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_i && (op_i == 4'd10 || op_i == 4'd11)) |=> (flags_o == $past(flags_i))); // R9

   AST_SWAP_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_i && op_i == 4'd12) |=> (flags_o == $past(flags_i)));           // R10

   AST_RESERVED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_i && op_i >= 4'd13) |=> (result_o == $past(a_i) && flags_o == $past(flags_i))); // R11
endmodule

bind alu16q alu16q_chk #(.W(W)) chk_i (
   .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .op_i(op_i), .a_i(a_i),
   .flags_i(flags_i), .result_o(result_o), .flags_o(flags_o)
);

// File: tb/alu16q_tb_top.sv
module alu16q_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exec_i = 1'b0;
   logic [3:0]  op_i = '0;
   logic [15:0] a_i = '0, b_i = '0;
   logic [6:0]  flags_i = '0;
   logic [15:0] result_o;
   logic [6:0]  flags_o;

   int n_vec = 0;
   int n_bad = 0;
   int exp_res = 0;
   int exp_flg = 0;
   bit finished = 1'b0;

   always #10ns clk = ~clk;

   alu16q dut_i (
      .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .op_i(op_i),
      .a_i(a_i), .b_i(b_i), .flags_i(flags_i),
      .result_o(result_o), .flags_o(flags_o)
   );

   function automatic string req_of(int op);
      case (op)
         0, 1:          return "R3";
         2, 3:          return "R4";
         4, 5, 6, 7:    return "R6";
         8:             return "R7";
         9:             return "R8";
         10, 11:        return "R9";
         12:            return "R10";
         default:       return "R11";
      endcase
   endfunction

   // behavioural reference: returns {flags, result}
   task automatic model(input int op, input int a, input int b, input int f,
                        output int r, output int nf);
      int s, bb, mask, c, qc, hc, tc, o;
      mask = 0; c = 0; qc = 0; hc = 0; tc = 0; o = 0;
      case (op)
         0, 1: begin
            bb = (op == 1) ? 1 : b;
            s  = a + bb;
            c  = (s > 65535) ? 1 : 0;
            qc = ((a % 16) + (bb % 16)) >= 16;
            hc = ((a % 256) + (bb % 256)) >= 256;
            tc = ((a % 4096) + (bb % 4096)) >= 4096;
            r  = s % 65536;
            o  = (((a ^ r) & (bb ^ r) & 32768) != 0);
            mask = 127;
         end
         2, 3: begin
            bb = (op == 3) ? 1 : b;
            r  = (a - bb + 65536) % 65536;
            c  = a < bb;
            qc = (a % 16) < (bb % 16);
            hc = (a % 256) < (bb % 256);
            tc = (a % 4096) < (bb % 4096);
            o  = (((a ^ bb) & (a ^ r) & 32768) != 0);
            mask = 127;
         end
         4: begin r = a & b; mask = 16; end
         5: begin r = a | b; mask = 16; end
         6: begin r = a ^ b; mask = 16; end
         7: begin r = 65535 - a; mask = 16; end
         8: begin r = ((a * 2) % 65536) + (f & 1); c = a / 32768; mask = 17; end
         9: begin r = (a / 2) + (f & 1) * 32768; c = a % 2; mask = 17; end
         10: r = ((a * 2) % 65536) + a / 32768;
         11: r = (a / 2) + (a % 2) * 32768;
         12: r = (a % 256) * 256 + a / 256;
         default: r = a;
      endcase
      nf = c + qc * 2 + hc * 4 + tc * 8 + ((r == 0) ? 16 : 0)
         + ((r >= 32768) ? 32 : 0) + o * 64;
      nf = (f & (127 - mask)) | (nf & mask);
   endtask

   task automatic compare(input string req);
      n_vec++;
      if (int'(result_o) != exp_res || int'(flags_o) != exp_flg) begin
         n_bad++;
         $display("FAIL %s: result %h flags %b, expected result %h flags %b",
                  req, result_o, flags_o, exp_res[15:0], exp_flg[6:0]);
      end
   endtask

   task automatic apply(input bit ex, input int op, input int a, input int b,
                        input int f, input string note);
      int r, nf;
      exec_i = ex; op_i = op[3:0]; a_i = a[15:0]; b_i = b[15:0]; flags_i = f[6:0];
      @(posedge clk);
      if (ex) begin
         model(op, a, b, f, r, nf);
         exp_res = r; exp_flg = nf;
      end
      @(negedge clk);
      compare(ex ? {req_of(op), " ", note} : {"R2 hold ", note});
   endtask

   initial begin
      #(20ns * 200000);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      a_i = 16'hBEEF; exec_i = 1'b1; op_i = 4'd0; flags_i = 7'h7F;
      repeat (3) @(posedge clk);
      @(negedge clk);
      compare("R1 reset");
      rst_n = 1'b1;

      // R3 quarter-boundary carries
      apply(1, 1, 16'h000F, 0, 0, "inc QC");
      apply(1, 1, 16'h00FF, 0, 0, "inc HC");
      apply(1, 1, 16'h0FFF, 0, 0, "inc TC");
      apply(1, 0, 16'hFFFF, 1, 0, "add wrap zero");
      apply(1, 0, 16'h1234, 16'h4321, 127, "add no carry");
      // R5 overflow at sign boundary
      apply(1, 1, 16'h7FFF, 0, 0, "R5 inc overflow");
      // R4 borrows
      apply(1, 3, 16'h0000, 0, 0, "dec borrow all");
      apply(1, 3, 16'h8000, 0, 0, "R5 dec overflow");
      apply(1, 2, 16'h1000, 16'h0001, 0, "sub borrow low three");
      apply(1, 2, 16'h5555, 16'h5555, 127, "sub equal");
      // R6 logic
      apply(1, 4, 16'hF0F0, 16'h0F0F, 111, "and zero");
      apply(1, 5, 16'h00F0, 16'h0F00, 127, "or");
      apply(1, 6, 16'hAAAA, 16'hAAAA, 0, "xor zero");
      apply(1, 7, 16'hFFFF, 0, 111, "not zero");
      // R7 / R8 shifts with both carries in
      apply(1, 8, 16'h8000, 0, 0, "shl to zero");
      apply(1, 8, 16'h4001, 0, 127, "shl carry in");
      apply(1, 9, 16'h0001, 0, 0, "shr to zero");
      apply(1, 9, 16'h8002, 0, 1, "shr carry in");
      // R9 / R10 rotates and swap
      apply(1, 10, 16'h8001, 0, 127, "rol");
      apply(1, 11, 16'h8001, 0, 0, "ror");
      apply(1, 12, 16'h12AB, 0, 85, "swap");
      apply(1, 12, 16'h0000, 0, 0, "swap zero keeps flags");
      // R11 reserved
      apply(1, 13, 16'hC0DE, 16'h1111, 42, "code 13");
      apply(1, 15, 16'h0000, 16'hFFFF, 127, "code 15");
      // R2 hold
      apply(0, 0, 16'hFFFF, 16'hFFFF, 0, "strobe low");

      for (int i = 0; i < 3000; i++) begin
         apply(($urandom % 5) != 0, $urandom % 16, $urandom % 65536,
               $urandom % 65536, $urandom % 128, "random");
      end

      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule